// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block supplies the bytes that an interrupt controller returns on its data bus while an 8-bit processor runs a three-pulse interrupt acknowledge. The processor lowers an active-low acknowledge line three times. On the first pulse the block returns a subroutine-call opcode. On the second it returns the low byte of the handler address. On the third it returns the high byte. It counts the pulses itself and restarts at the call opcode once the third pulse has ended.

On the falling edge of the first pulse, the block captures the number of the winning request from the priority logic. It also raises a one-cycle in-service-set strobe for that request. The captured number is held for the rest of the cycle, so the address bytes do not change if priorities change in the meantime.

The low address byte puts programmed upper bits above the captured request number. A configuration bit selects handler spacing of 4 or 8 bytes. The high byte is a fully programmed register. When automatic end-of-interrupt is configured, the block raises a one-cycle in-service-clear strobe for the captured request as the third pulse ends.

Top module: `iack_vec_seq`

## Requirements
- R1: For the first cycles after reset is released, with acknowledge held high: `dout_en`, `isr_set` and `isr_clr` are all 0.
- R2: During the first acknowledge pulse, `dout_en` is 1 and `dout` is 8'hCD.
- R3: In the cycle where `ack_n` is first seen low on the first pulse, `isr_set` is 1 and `isr_set_id` equals `win_id`. In the next cycle `isr_set` is 0.
- R4: With `cfg_spacing4`=1, the second pulse returns {cfg_base[2:0], id[2:0], 2'b00}. Here id is the request number captured on the first pulse.
- R5: With `cfg_spacing4`=0, the second pulse returns {cfg_base[2:1], id[2:0], 3'b000}. Bit 0 of `cfg_base` has no effect on the result.
- R6: During the third pulse, `dout` equals `cfg_hi`.
- R7: Changes on `win_id` after the first pulse do not alter the low byte, and `isr_set` stays 0 during the second and third pulses.
- R8: With `cfg_auto_eoi`=1, `isr_clr` is 1 for one cycle, in the cycle where `ack_n` is first seen high after the third pulse, and `isr_clr_id` then equals the captured id. With `cfg_auto_eoi`=0, `isr_clr` stays 0.
- R9: After the third pulse ends, the next pulse is treated as a first pulse again and returns 8'hCD.
- R10: `dout_en` is 0 whenever `ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_n | input | 1 | Active-low acknowledge pulse from the processor, synchronous to clk |
| win_id | input | ID_W | Number of the highest-priority pending request |
| cfg_base | input | DATA_W-ID_W-2 | Programmed upper bits of the low address byte |
| cfg_spacing4 | input | 1 | 1 = 4-byte handler spacing, 0 = 8-byte spacing |
| cfg_hi | input | DATA_W | Programmed high address byte |
| cfg_auto_eoi | input | 1 | 1 = clear in-service automatically at the end of the sequence |
| dout | output | DATA_W | Byte driven onto the data bus |
| dout_en | output | 1 | Data bus output enable |
| isr_set | output | 1 | One-cycle strobe that sets the in-service bit |
| isr_set_id | output | ID_W | Request number to mark as in service |
| isr_clr | output | 1 | One-cycle automatic in-service clear strobe |
| isr_clr_id | output | ID_W | Request number to clear |

## Verification
The bench builds the block with its default widths: an 8-bit bus and a 3-bit request number. This keeps the whole configuration space small enough to sweep in full. Every request number is run against every value of the three programmed base bits, under both spacings and both end-of-interrupt modes, with a varying high byte. Every low-byte layout and every strobe timing is therefore checked against values computed arithmetically. Each sequence also disturbs `win_id` after the first pulse, to show that the request number is captured, and runs back to back with the next sequence, to exercise the restart.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam logic [7:0] CALL_OP = 8'hCD;

  typedef enum logic [1:0] {
    PH_CALL = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } iack_phase_e;
endpackage

// File: rtl/ack_seq_ctr.sv
module ack_seq_ctr
  import iack_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ack_n,
  output logic        fall,
  output logic        rise,
  output iack_phase_e phase
);
  logic        ack_q;
  iack_phase_e phase_q, phase_d;
  logic        phase_en;

  assign fall  = ack_q & ~ack_n;
  assign rise  = ~ack_q & ack_n;
  assign phase = phase_q;

  // Advance the byte position on the trailing edge of each pulse
  always_comb begin
    phase_en = rise;
    unique case (phase_q)
      PH_CALL: phase_d = PH_LO;
      PH_LO:   phase_d = PH_HI;
      default: phase_d = PH_CALL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b1;
      phase_q <= PH_CALL;
    end else begin
      ack_q <= ack_n;
      if (phase_en) phase_q <= phase_d;
    end
  end

  p_phase_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != 2'd3);
  p_wrap_after_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && phase_q == PH_HI) |=> (phase_q == PH_CALL));
endmodule

// File: rtl/vec_lo_build.sv
module vec_lo_build #(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic [ID_W-1:0]        id,
  input  logic [DATA_W-ID_W-3:0] base,
  input  logic                   spacing4,
  output logic [DATA_W-1:0]      lo
);
  localparam int B4 = DATA_W - ID_W - 2;
  localparam int B8 = DATA_W - ID_W - 3;

  logic [DATA_W-1:0] lo4, lo8;

  assign lo4 = {base, id, 2'b00};
  assign lo8 = {base[B4-1 -: B8], id, 3'b000};
  assign lo  = spacing4 ? lo4 : lo8;
endmodule

// File: rtl/iack_vec_seq.sv
module iack_vec_seq
  import iack_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ID_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ack_n,
  input  logic [ID_W-1:0]        win_id,
  input  logic [DATA_W-ID_W-3:0] cfg_base,
  input  logic                   cfg_spacing4,
  input  logic [DATA_W-1:0]      cfg_hi,
  input  logic                   cfg_auto_eoi,
  output logic [DATA_W-1:0]      dout,
  output logic                   dout_en,
  output logic                   isr_set,
  output logic [ID_W-1:0]        isr_set_id,
  output logic                   isr_clr,
  output logic [ID_W-1:0]        isr_clr_id
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rs_q;
  logic              rst_int_n;
  logic              fall, rise;
  iack_phase_e       phase;
  logic [ID_W-1:0]   id_q, id_d;
  logic              id_en;
  logic [DATA_W-1:0] lo_byte;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[SYNC_N-1];

  ack_seq_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ack_n (ack_n),
    .fall  (fall),
    .rise  (rise),
    .phase (phase)
  );

  // Capture the winner on the leading edge of the first pulse
  always_comb begin
    id_en = fall && (phase == PH_CALL);
    id_d  = win_id;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  id_q <= '0;
    else if (id_en)  id_q <= id_d;
  end

  vec_lo_build #(.DATA_W(DATA_W), .ID_W(ID_W)) u_lo (
    .id       (id_q),
    .base     (cfg_base),
    .spacing4 (cfg_spacing4),
    .lo       (lo_byte)
  );

  always_comb begin
    unique case (phase)
      PH_CALL: dout = DATA_W'(CALL_OP);
      PH_LO:   dout = lo_byte;
      default: dout = cfg_hi;
    endcase
  end

  assign dout_en    = ~ack_n;
  assign isr_set    = id_en;
  assign isr_set_id = win_id;
  assign isr_clr    = rise && (phase == PH_HI) && cfg_auto_eoi;
  assign isr_clr_id = id_q;

  p_set_pulse_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    isr_set |=> !isr_set);
  p_set_while_low_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    isr_set |-> !ack_n);
  p_clr_gated_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    isr_clr |-> (ack_n && cfg_auto_eoi));
  p_id_held_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase != PH_CALL) |-> $stable(id_q));
endmodule

// File: tb/test_iack_vec_seq.sv
module test_iack_vec_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ack_n;
  logic [2:0] win_id;
  logic [2:0] cfg_base;
  logic       cfg_spacing4;
  logic [7:0] cfg_hi;
  logic       cfg_auto_eoi;
  logic [7:0] dout;
  logic       dout_en;
  logic       isr_set;
  logic [2:0] isr_set_id;
  logic       isr_clr;
  logic [2:0] isr_clr_id;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  iack_vec_seq i_iack_vec_seq (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .win_id(win_id),
    .cfg_base(cfg_base), .cfg_spacing4(cfg_spacing4), .cfg_hi(cfg_hi),
    .cfg_auto_eoi(cfg_auto_eoi), .dout(dout), .dout_en(dout_en),
    .isr_set(isr_set), .isr_set_id(isr_set_id), .isr_clr(isr_clr),
    .isr_clr_id(isr_clr_id)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(logic [2:0] id, logic [2:0] base, logic sp4,
                         logic aeoi, logic [7:0] hi);
    logic [7:0] exp_lo;
    exp_lo = sp4 ? {base, id, 2'b00} : {base[2:1], id, 3'b000};
    @(negedge clk);
    win_id = id; cfg_base = base; cfg_spacing4 = sp4;
    cfg_auto_eoi = aeoi; cfg_hi = hi;
    // first pulse
    @(negedge clk); ack_n = 1'b0; #1;
    check("R2 en", {7'd0, dout_en}, 8'd1);
    check("R2/R9 call", dout, 8'hCD);
    check("R3 set", {7'd0, isr_set}, 8'd1);
    check("R3 set_id", {5'd0, isr_set_id}, {5'd0, id});
    @(negedge clk); win_id = ~id; #1;
    check("R3 set one cycle", {7'd0, isr_set}, 8'd0);
    @(negedge clk); ack_n = 1'b1; #1;
    check("R10 en off", {7'd0, dout_en}, 8'd0);
    check("R8 no early clr", {7'd0, isr_clr}, 8'd0);
    // second pulse
    @(negedge clk); ack_n = 1'b0; #1;
    check(sp4 ? "R4 lo4 R7" : "R5 lo8 R7", dout, exp_lo);
    check("R7 no set p2", {7'd0, isr_set}, 8'd0);
    @(negedge clk);
    @(negedge clk); ack_n = 1'b1; #1;
    check("R10 en off", {7'd0, dout_en}, 8'd0);
    // third pulse
    @(negedge clk); ack_n = 1'b0; #1;
    check("R6 hi", dout, hi);
    check("R7 no set p3", {7'd0, isr_set}, 8'd0);
    @(negedge clk);
    @(negedge clk); ack_n = 1'b1; #1;
    check("R8 clr", {7'd0, isr_clr}, {7'd0, aeoi});
    if (aeoi) check("R8 clr_id", {5'd0, isr_clr_id}, {5'd0, id});
    @(negedge clk); #1;
    check("R8 clr one cycle", {7'd0, isr_clr}, 8'd0);
  endtask

  initial begin
    rst_n = 1'b0; ack_n = 1'b1; win_id = '0; cfg_base = '0;
    cfg_spacing4 = 1'b0; cfg_hi = '0; cfg_auto_eoi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      check("R1 en", {7'd0, dout_en}, 8'd0);
      check("R1 set", {7'd0, isr_set}, 8'd0);
      check("R1 clr", {7'd0, isr_clr}, 8'd0);
    end
    for (int sp = 0; sp < 2; sp++)
      for (int ae = 0; ae < 2; ae++)
        for (int b = 0; b < 8; b++)
          for (int i = 0; i < 8; i++)
            run_seq(3'(i), 3'(b), sp[0], ae[0], 8'(i * 37 + b * 11 + sp * 3 + ae));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule